// File: doc/BRIEF.md
# Serial Converter Interface Emulator

This block stands in for the digital side of a 12-bit sampling converter that has a three-wire serial port. A host pulls an active-low start strobe down to begin a frame and then toggles a serial clock. The block holds the word on its parallel sample input at the moment the strobe falls. It then drives that word out one bit per clock rising edge: three leading zeros first, then the twelve data bits with the most significant bit first. The data output has a separate enable, so a pad or a testbench can turn it into a three-state line.

The same strobe and clock pins also control power. The length of the strobe-low window, counted in serial clock rising edges at the moment the strobe rises, picks one of three outcomes:
- a short window aborts the frame;
- a medium window steps the power state down by one level;
- a long window returns the block to normal operation.

The block shows the current power state and a reference-enable flag. Both inputs are brought into the system clock domain through a synchronizer and then edge-detected. Every reaction therefore comes a fixed number of system clocks after the pin changes.

Top module: `serial_adc_emu`

## Requirements
- R1: After reset the data enable is low, the power state is NORMAL (code 2'b00), and the reference enable is high.
- R2: A falling strobe starts a frame. The data enable goes high and the data output is driven low. The sample input is captured at that moment, and later changes to it do not affect the frame.
- R3: After rising edge k of the frame, the output shows a zero for k = 1 to 3. For k = 4 to 15 it shows sample bit 15-k: the two's complement word is passed unchanged, with the sign bit at edge 4 and the least significant bit at edge 15.
- R4: The data output changes only on a serial clock rising edge or at frame start. Between those events it holds its value.
- R5: If the strobe stays low, the output keeps driving through the 16th rising edge. It is released at the 17th rising edge, or at the strobe rise if that comes first.
- R6: A strobe rise after 3 to 13 rising edges steps the power state down one level and releases the output at once. NORMAL goes to PARTIAL (2'b01), PARTIAL goes to FULL (2'b10), and FULL stays FULL.
- R7: A strobe rise after fewer than 3 rising edges aborts the frame. The output is released and the power state does not change.
- R8: A strobe rise after 14 or more rising edges returns the power state to NORMAL from any state.
- R9: A strobe rise after exactly 14 or 15 rising edges leaves the output driving. Bits keep shifting until the 16th rising edge, which releases it.
- R10: The reference enable is low only in the FULL state. It changes only when a strobe rise ends a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low frame strobe from the host |
| ser_clk | input | 1 | Serial clock from the host |
| sample_in | input | DATA_W | Two's complement sample to be sent |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable for the serial data line |
| pwr_mode | output | 2 | Power state: 00 normal, 01 partial, 10 full |
| ref_en | output | 1 | Reference enable flag |

## Verification
A frame counter that is off by one shows up at once as a word shifted by one bit position. The first sign of it is the sign bit arriving a clock early or late, so the host reads a wrong word in the same frame. A wrong count at the strobe rise shows up on `pwr_mode` within the synchronizer latency after that rise. The fault can be a boundary misjudged at 3, 13, 14 or 16 edges, or a power state stepped twice. The enable output gives away a release that comes one edge too early or too late, on the edge where the host would still be sampling.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_PARTIAL = 2'b01,
    PM_FULL    = 2'b10
  } pwr_mode_e;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'b00,
    FS_ACTIVE = 2'b01,
    FS_TAIL   = 2'b10
  } frame_st_e;

  // Power state that follows a strobe rise after 'edges' serial clock edges.
  function automatic pwr_mode_e mode_after(input pwr_mode_e cur,
                                           input int unsigned edges,
                                           input int unsigned lead,
                                           input int unsigned wake);
    if (edges < lead) begin
      return cur;
    end else if (edges < wake) begin
      return (cur == PM_NORMAL) ? PM_PARTIAL : PM_FULL;
    end
    return PM_NORMAL;
  endfunction

  // Serial bit presented after rising edge 'edge_no' of a frame.
  function automatic logic frame_bit(input logic [31:0] word,
                                     input int unsigned edge_no,
                                     input int unsigned lead,
                                     input int unsigned width);
    int unsigned idx;
    if (edge_no > lead && edge_no <= lead + width) begin
      idx = lead + width - edge_no;
      return word[idx[4:0]];
    end
    return 1'b0;
  endfunction

endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= {STAGES{RST_VAL}};
    end else begin
      sh_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/adc_emu_pins.sv
module adc_emu_pins #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic ser_clk,
  output logic strb_fall,
  output logic strb_rise,
  output logic sclk_rise
);
  logic s_strb, s_sclk;
  logic p_strb_q, p_sclk_q;

  adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d(start_n), .q(s_strb)
  );

  adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(s_sclk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_strb_q <= 1'b1;
      p_sclk_q <= 1'b0;
    end else begin
      p_strb_q <= s_strb;
      p_sclk_q <= s_sclk;
    end
  end

  assign strb_fall = p_strb_q & ~s_strb;
  assign strb_rise = ~p_strb_q & s_strb;
  assign sclk_rise = ~p_sclk_q & s_sclk;
endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame
  import adc_emu_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 3,
  parameter int WAKE_EDGES = 14,
  parameter int HOLD_EDGE  = LEAD_ZEROS + DATA_W + 1,
  parameter int CNT_W      = $clog2(HOLD_EDGE + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_fall,
  input  logic              strb_rise,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] sample_in,
  output logic              frame_start,
  output logic              decide,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] CNT_MAX_C = CNT_W'(HOLD_EDGE + 1);
  localparam logic [CNT_W-1:0] HOLD_C    = CNT_W'(HOLD_EDGE);
  localparam logic [CNT_W-1:0] WAKE_C    = CNT_W'(WAKE_EDGES);

  frame_st_e         st_q;
  logic [DATA_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic              next_bit;

  assign frame_start = strb_fall && (st_q != FS_ACTIVE);
  assign decide      = strb_rise && (st_q == FS_ACTIVE);
  assign cnt_inc     = (cnt_q == CNT_MAX_C) ? cnt_q : cnt_q + CNT_W'(1);
  assign next_bit    = frame_bit(32'(hold_q), 32'(cnt_inc), LEAD_ZEROS, DATA_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      hold_q <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (frame_start) begin
      st_q   <= FS_ACTIVE;
      cnt_q  <= '0;
      hold_q <= sample_in;
      sdo    <= 1'b0;
      sdo_oe <= 1'b1;
    end else begin
      case (st_q)
        FS_ACTIVE: begin
          if (strb_rise) begin
            if (cnt_q >= WAKE_C && cnt_q < HOLD_C) begin
              st_q <= FS_TAIL;
            end else begin
              st_q   <= FS_IDLE;
              sdo_oe <= 1'b0;
            end
          end else if (sclk_rise) begin
            cnt_q <= cnt_inc;
            sdo   <= next_bit;
            if (cnt_inc > HOLD_C) sdo_oe <= 1'b0;
          end
        end
        FS_TAIL: begin
          if (sclk_rise) begin
            cnt_q <= cnt_inc;
            sdo   <= next_bit;
            if (cnt_inc >= HOLD_C) begin
              st_q   <= FS_IDLE;
              sdo_oe <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_emu_mode.sv
module adc_emu_mode
  import adc_emu_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int LEAD_ZEROS = 3,
  parameter int WAKE_EDGES = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide,
  input  logic [CNT_W-1:0] cnt_q,
  output pwr_mode_e        mode_q,
  output logic             ref_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= PM_NORMAL;
    end else if (decide) begin
      mode_q <= mode_after(mode_q, 32'(cnt_q), LEAD_ZEROS, WAKE_EDGES);
    end
  end

  assign ref_en = (mode_q != PM_FULL);
endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 3,
  parameter int WAKE_EDGES  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              ser_clk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [1:0]        pwr_mode,
  output logic              ref_en
);
  localparam int HOLD_EDGE = LEAD_ZEROS + DATA_W + 1;
  localparam int CNT_W     = $clog2(HOLD_EDGE + 2);

  logic             strb_fall, strb_rise, sclk_rise;
  logic             frame_start, decide;
  logic [CNT_W-1:0] cnt_q;
  pwr_mode_e        mode_q;

  adc_emu_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .ser_clk(ser_clk),
    .strb_fall(strb_fall), .strb_rise(strb_rise), .sclk_rise(sclk_rise)
  );

  adc_emu_frame #(
    .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .WAKE_EDGES(WAKE_EDGES),
    .HOLD_EDGE(HOLD_EDGE), .CNT_W(CNT_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .strb_fall(strb_fall), .strb_rise(strb_rise),
    .sclk_rise(sclk_rise), .sample_in(sample_in), .frame_start(frame_start),
    .decide(decide), .cnt_q(cnt_q), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  adc_emu_mode #(
    .CNT_W(CNT_W), .LEAD_ZEROS(LEAD_ZEROS), .WAKE_EDGES(WAKE_EDGES)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .decide(decide), .cnt_q(cnt_q),
    .mode_q(mode_q), .ref_en(ref_en)
  );

  assign pwr_mode = mode_q;
endmodule

// File: rtl/adc_emu_checker.sv
module adc_emu_checker #(
  parameter int CNT_W     = 5,
  parameter int LEAD      = 3,
  parameter int WAKE      = 14,
  parameter int HOLD_EDGE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_rise,
  input logic             frame_start,
  input logic             decide,
  input logic [CNT_W-1:0] cnt_q,
  input logic             sdo,
  input logic             sdo_oe,
  input logic [1:0]       pwr_mode,
  input logic             ref_en
);
  a_r2_start_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sdo_oe && !sdo));

  a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !frame_start) |=> $stable(sdo));

  a_r5_late_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CNT_W'(HOLD_EDGE)) |-> !sdo_oe);

  a_r6_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b11);

  a_r6_full_from_partial: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_mode == 2'b10) |-> $past(pwr_mode) == 2'b01);

  a_r6_powerdown_release: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && cnt_q < CNT_W'(WAKE)) |=> !sdo_oe);

  a_r7_short_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && cnt_q < CNT_W'(LEAD)) |=> $stable(pwr_mode));

  a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && cnt_q >= CNT_W'(WAKE)) |=> pwr_mode == 2'b00);

  a_r10_ref_only_at_decide: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> $stable(ref_en));
endmodule

bind serial_adc_emu adc_emu_checker #(
  .CNT_W(CNT_W), .LEAD(LEAD_ZEROS), .WAKE(WAKE_EDGES), .HOLD_EDGE(HOLD_EDGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .frame_start(frame_start),
  .decide(decide), .cnt_q(cnt_q), .sdo(sdo), .sdo_oe(sdo_oe),
  .pwr_mode(pwr_mode), .ref_en(ref_en)
);

// File: tb/tb_serial_adc_emu.sv
`timescale 1ns/1ps
module tb_serial_adc_emu;
  localparam int DW   = 12;
  localparam int LEAD = 3;
  localparam int WAKE = 14;
  localparam int HOLD = 16;
  localparam int HP   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_n = 1'b1;
  logic          ser_clk = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic          sdo, sdo_oe, ref_en;
  logic [1:0]    pwr_mode;
  logic [1:0]    em = 2'b00;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #2.5 clk = ~clk;

  serial_adc_emu dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .ser_clk(ser_clk),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe),
    .pwr_mode(pwr_mode), .ref_en(ref_en)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_mode(input logic [1:0] m, input int n);
    if (n < LEAD) return m;
    if (n < WAKE) return (m == 2'b00) ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  // Stream of 16 bit slots: four zero slots, then the word MSB first.
  function automatic logic exp_bit(input logic [DW-1:0] d, input int j);
    logic [15:0] stream;
    stream = {4'b0000, d};
    if (j < 16) return stream[15-j];
    return 1'b0;
  endfunction

  task automatic frame(input logic [DW-1:0] d, input int n);
    string rq;
    sample_in = d;
    start_n = 1'b0;
    wclk(HP);
    sample_in = ~d;
    chk("R2 start drive", {30'd0, sdo_oe, sdo}, 32'h2);
    for (int k = 1; k <= n; k++) begin
      ser_clk = 1'b1;
      wclk(HP);
      chk("R5 enable while low", {31'd0, sdo_oe}, {31'd0, (k <= HOLD)});
      if (k <= HOLD) chk("R3 bit", {31'd0, sdo}, {31'd0, exp_bit(d, k)});
      ser_clk = 1'b0;
      wclk(HP);
      if (k <= HOLD) chk("R4 hold", {31'd0, sdo}, {31'd0, exp_bit(d, k)});
    end
    start_n = 1'b1;
    wclk(HP);
    em = model_mode(em, n);
    rq = (n < LEAD) ? "R7 mode" : (n < WAKE) ? "R6 mode" : "R8 mode";
    chk(rq, {30'd0, pwr_mode}, {30'd0, em});
    chk("R10 ref", {31'd0, ref_en}, {31'd0, (em != 2'b10)});
    if (n >= WAKE && n < HOLD) begin
      chk("R9 tail enable", {31'd0, sdo_oe}, 32'd1);
      for (int k = n + 1; k <= HOLD; k++) begin
        ser_clk = 1'b1;
        wclk(HP);
        if (k < HOLD) begin
          chk("R9 tail enable", {31'd0, sdo_oe}, 32'd1);
          chk("R9 tail bit", {31'd0, sdo}, {31'd0, exp_bit(d, k)});
        end else begin
          chk("R9 release", {31'd0, sdo_oe}, 32'd0);
        end
        ser_clk = 1'b0;
        wclk(HP);
      end
    end else begin
      rq = (n < LEAD) ? "R7 release" : (n < WAKE) ? "R6 release" : "R5 release";
      chk(rq, {31'd0, sdo_oe}, 32'd0);
    end
    wclk(HP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    chk("R1 enable", {31'd0, sdo_oe}, 32'd0);
    chk("R1 mode", {30'd0, pwr_mode}, 32'd0);
    chk("R1 ref", {31'd0, ref_en}, 32'd1);

    // Data sweep with full 16-edge frames (R3): corner words and a stride.
    frame(12'h800, HOLD);
    frame(12'h7FF, HOLD);
    frame(12'hFFF, HOLD);
    frame(12'h000, HOLD);
    for (int i = 0; i < 24; i++) begin
      frame(DW'((i * 1103 + 77) % 4096), HOLD);
    end

    // Edge-count sweep from NORMAL; wake back up after any power-down.
    for (int n = 0; n <= 20; n++) begin
      frame(DW'(n * 291 + 5), n);
      if (em != 2'b00) frame(12'h5A3, WAKE);
    end

    // Step-down chain, abort inside FULL, and wake from each state.
    frame(12'h123, 5);
    frame(12'h456, 9);
    frame(12'h789, 13);
    frame(12'hABC, 2);
    frame(12'hDEF, 1);
    frame(12'h321, 15);
    frame(12'h654, 3);
    frame(12'h987, 13);
    frame(12'hCBA, 20);
    frame(12'h0F0, 3);
    frame(12'h0F0, 0);
    frame(12'hF0F, 14);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule